// File: doc/BRIEF.md
# SPI Slave Write-Command Front End

This block sits between an SPI host and an I2C master engine. The host selects the block by pulling an active-low chip select, clocks in a message on MOSI, and releases the select. The block recovers bytes from the serial stream in the system clock domain and checks that the first byte is the write command. It takes the second byte as the number of payload bytes and the third byte as the 7-bit target address. The bytes that follow are stored in order in an on-chip payload buffer.

The frame is judged when the select is released. If the number of payload bytes received matches the declared count, the block raises a one-cycle start request. The request carries the address and the count, and the I2C engine then reads the payload out of the buffer by index. A frame that ends early or runs long, after a valid command byte, produces a one-cycle rejection pulse instead. A frame with any other command byte is dropped without a word.

The count is passed on as the host sent it, even above the buffer limit of 96, so that the engine downstream can report the bad count. Only the first 96 payload bytes are ever stored. MISO is held at a fixed idle level.

Top module: `spi_wr_parser`

## Requirements
- R1: After reset, `req_valid` and `req_bad` are 0, `req_addr` and `req_count` are 0, and `spi_miso` is 0.
- R2: Bits are taken from MOSI on each rising SCLK edge while `spi_csn` is low, most significant bit first, eight bits to a byte (SPI mode 0).
- R3: SCLK and MOSI activity while `spi_csn` is high is ignored. Bit counting restarts each time the select falls, so bytes stay aligned to the select.
- R4: The first byte of a frame must be 0x00. Any other value causes the whole frame to be discarded: no request, no rejection, no buffer write, and unchanged outputs.
- R5: The second byte is the declared payload count. It appears unchanged on `req_count` with the request, including values above 96.
- R6: The third byte supplies the address in bits 7:1, which is presented on the 7-bit `req_addr`. Bit 0 of that byte has no effect.
- R7: Payload byte k (k = 1..N) is stored at buffer index k-1. It is read on `rd_data` combinationally from `rd_idx`, and an index of 96 or more reads 0.
- R8: At most 96 payload bytes are stored. Bytes past the 96th are counted but not written, so index 95 holds the 96th byte.
- R9: When the select rises on a frame with command 0x00, a full header and exactly the declared number of payload bytes, `req_valid` pulses high for one cycle a few system cycles later.
- R10: When the select rises on a frame with command 0x00 but a missing count or address byte, or a payload count that differs from the declared one, `req_bad` pulses for one cycle. `req_valid` stays low in that case, and `req_addr` and `req_count` keep their values.
- R11: A byte whose last rising SCLK edge coincides with the rising select is counted before the frame is judged.
- R12: `req_addr` and `req_count` change only in the cycle in which `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the host, held at idle level |
| rd_idx | input | 7 | Payload buffer read index |
| rd_data | output | 8 | Payload byte at `rd_idx` |
| req_valid | output | 1 | One-cycle start request to the I2C engine |
| req_bad | output | 1 | One-cycle rejection of a malformed write frame |
| req_addr | output | 7 | Target address of the latest accepted frame |
| req_count | output | 8 | Declared payload count of the latest accepted frame |

## Verification
The completion of the final byte and the release of the select can land in the same system cycle. The frame decision must then include that byte, or a correct frame is rejected as one byte short. The bench provokes this by raising SCLK and the select on the same edge for the last bit. It then expects a start request, not a rejection, together with the right count and a correctly stored final byte. Random frames and directed short, long, over-limit and wrong-command frames check the other verdicts against counts computed in the bench.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

    localparam int BYTE_W      = 8;
    localparam int MAX_PAYLOAD = 96;
    localparam int IDX_W       = $clog2(MAX_PAYLOAD);
    localparam int GOT_W       = BYTE_W + 1;
    localparam int ADDR_W      = 7;
    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h00;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_COUNT,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        V_NONE,
        V_GO,
        V_BAD
    } verdict_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] count;
    } wr_req_t;

    function automatic verdict_e judge_frame(
        input phase_e            ph,
        input logic [BYTE_W-1:0] declared,
        input logic [GOT_W-1:0]  received
    );
        verdict_e v;
        case (ph)
            PH_COUNT, PH_ADDR: v = V_BAD;
            PH_DATA:           v = (received == {1'b0, declared}) ? V_GO : V_BAD;
            default:           v = V_NONE;
        endcase
        return v;
    endfunction

    function automatic logic [GOT_W-1:0] sat_inc(input logic [GOT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic mosi_in,
    input  logic csn_in,
    output logic sclk_rise,
    output logic mosi_s,
    output logic sel,
    output logic cs_rise
);
    logic [STAGES-1:0] sclk_ff;
    logic [STAGES-1:0] mosi_ff;
    logic [STAGES-1:0] csn_ff;
    logic              sclk_d;
    logic              csn_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sclk_ff[0] <= 1'b0;
                        mosi_ff[0] <= 1'b0;
                        csn_ff[0]  <= 1'b1;
                    end else begin
                        sclk_ff[0] <= sclk_in;
                        mosi_ff[0] <= mosi_in;
                        csn_ff[0]  <= csn_in;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sclk_ff[g] <= 1'b0;
                        mosi_ff[g] <= 1'b0;
                        csn_ff[g]  <= 1'b1;
                    end else begin
                        sclk_ff[g] <= sclk_ff[g-1];
                        mosi_ff[g] <= mosi_ff[g-1];
                        csn_ff[g]  <= csn_ff[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_ff[STAGES-1];
            csn_d  <= csn_ff[STAGES-1];
        end
    end

    assign sclk_rise = sclk_ff[STAGES-1] & ~sclk_d;
    assign mosi_s    = mosi_ff[STAGES-1];
    assign sel       = ~csn_d;
    assign cs_rise   = csn_ff[STAGES-1] & ~csn_d;

endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
    import spi_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sclk_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[BYTE_W-3:0], mosi_s};
        end
    end

    assign byte_vld = sel && sclk_rise && (bit_cnt == LAST_BIT);
    assign byte_val = {shreg, mosi_s};

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_wr_pkg::*;
#(
    parameter int MAX_BYTES = MAX_PAYLOAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              cs_rise,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              go,
    output logic              bad,
    output wr_req_t           req
);
    localparam logic [GOT_W-1:0] MAX_GOT = GOT_W'(MAX_BYTES);

    phase_e            phase_q, phase_n;
    logic [BYTE_W-1:0] cnt_q, cnt_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [GOT_W-1:0]  got_q, got_n;
    verdict_e          verdict;

    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q;
        addr_n  = addr_q;
        got_n   = got_q;
        wr_en   = 1'b0;
        wr_idx  = got_q[IDX_W-1:0];
        wr_data = byte_val;
        if (byte_vld) begin
            case (phase_q)
                PH_CMD:   phase_n = (byte_val == CMD_WRITE) ? PH_COUNT : PH_SKIP;
                PH_COUNT: begin
                    cnt_n   = byte_val;
                    phase_n = PH_ADDR;
                end
                PH_ADDR: begin
                    addr_n  = byte_val[BYTE_W-1:1];
                    phase_n = PH_DATA;
                end
                PH_DATA: begin
                    wr_en = (got_q < MAX_GOT);
                    got_n = sat_inc(got_q);
                end
                default: ;
            endcase
        end
        verdict = judge_frame(phase_n, cnt_n, got_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            addr_q  <= '0;
            got_q   <= '0;
            go      <= 1'b0;
            bad     <= 1'b0;
            req     <= '0;
        end else begin
            go  <= 1'b0;
            bad <= 1'b0;
            if (cs_rise) begin
                phase_q <= PH_CMD;
                got_q   <= '0;
                if (verdict == V_GO) begin
                    go         <= 1'b1;
                    req.addr   <= addr_n;
                    req.count  <= cnt_n;
                end else if (verdict == V_BAD) begin
                    bad <= 1'b1;
                end
            end else if (!sel) begin
                phase_q <= PH_CMD;
                got_q   <= '0;
            end else begin
                phase_q <= phase_n;
                cnt_q   <= cnt_n;
                addr_q  <= addr_n;
                got_q   <= got_n;
            end
        end
    end

endmodule

// File: rtl/spi_payload_buf.sv
module spi_payload_buf
    import spi_wr_pkg::*;
#(
    parameter int DEPTH = MAX_PAYLOAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] mem [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[e] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    mem[e] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = mem[i];
        end
    end

endmodule

// File: rtl/spi_wr_parser.sv
module spi_wr_parser
    import spi_wr_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   MAX_BYTES   = MAX_PAYLOAD,
    parameter logic MISO_IDLE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_csn,
    output logic              spi_miso,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              req_valid,
    output logic              req_bad,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BYTE_W-1:0] req_count
);
    logic              sclk_rise;
    logic              mosi_s;
    logic              sel;
    logic              cs_rise;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_widx;
    logic [BYTE_W-1:0] buf_wdata;
    wr_req_t           req;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (spi_sclk),
        .mosi_in   (spi_mosi),
        .csn_in    (spi_csn),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s),
        .sel       (sel),
        .cs_rise   (cs_rise)
    );

    spi_byte_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val)
    );

    spi_frame_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .cs_rise  (cs_rise),
        .byte_vld (byte_vld),
        .byte_val (byte_val),
        .wr_en    (buf_we),
        .wr_idx   (buf_widx),
        .wr_data  (buf_wdata),
        .go       (req_valid),
        .bad      (req_bad),
        .req      (req)
    );

    spi_payload_buf #(.DEPTH(MAX_BYTES)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we),
        .wr_idx  (buf_widx),
        .wr_data (buf_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign req_addr  = req.addr;
    assign req_count = req.count;
    assign spi_miso  = MISO_IDLE;

endmodule

// File: rtl/spi_wr_parser_chk.sv
module spi_wr_parser_chk
    import spi_wr_pkg::*;
#(
    parameter int MAX_BYTES = MAX_PAYLOAD
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_bad,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BYTE_W-1:0] req_count,
    input logic              cs_rise,
    input logic              sel,
    input logic              buf_we,
    input logic [IDX_W-1:0]  buf_widx
);
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_bad));                                  // R10
    AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);                                 // R9
    AST_GO_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(cs_rise));                             // R9
    AST_BAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        req_bad |-> $past(cs_rise));                               // R10
    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (32'(buf_widx) < MAX_BYTES));                   // R8
    AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> sel);                                           // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$stable(req_addr) || !$stable(req_count)) |-> req_valid); // R12
endmodule

bind spi_wr_parser spi_wr_parser_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_bad   (req_bad),
    .req_addr  (req_addr),
    .req_count (req_count),
    .cs_rise   (cs_rise),
    .sel       (sel),
    .buf_we    (buf_we),
    .buf_widx  (buf_widx)
);

// File: tb/spi_wr_parser_test.sv
`timescale 1ns/1ps
module spi_wr_parser_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_miso;
    logic [6:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       req_valid;
    logic       req_bad;
    logic [6:0] req_addr;
    logic [7:0] req_count;

    int checks = 0;
    int failures = 0;
    int n_go = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] fb [0:103];

    always #2.5 clk = ~clk;

    spi_wr_parser uut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_csn(spi_csn), .spi_miso(spi_miso), .rd_idx(rd_idx), .rd_data(rd_data),
        .req_valid(req_valid), .req_bad(req_bad), .req_addr(req_addr), .req_count(req_count)
    );

    always @(negedge clk) begin
        if (!rst && req_valid) n_go++;
        if (!rst && req_bad) n_bad++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] b, input bit cs_last);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = b[i];
            repeat (4) @(negedge clk);
            spi_sclk = 1'b1;
            if (cs_last && i == 0) spi_csn = 1'b1;
            repeat (4) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic send_frame(input int n, input bit cs_last);
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < n; k++) spi_byte(fb[k], cs_last && (k == n - 1));
        if (!(cs_last && n > 0)) begin
            repeat (4) @(negedge clk);
            spi_csn = 1'b1;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic noise_cs_high(input int n);
        for (int i = 0; i < n; i++) begin
            spi_mosi = 1'($urandom);
            repeat (3) @(negedge clk);
            spi_sclk = ~spi_sclk;
        end
        spi_sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // expect: 0 nothing, 1 start request, 2 rejection
    task automatic frame_check(input int n, input bit cs_last, input int expect_kind, input string tag);
        int g0 = n_go;
        int b0 = n_bad;
        logic [6:0] a0 = req_addr;
        logic [7:0] c0 = req_count;
        send_frame(n, cs_last);
        chk((n_go - g0) == (expect_kind == 1 ? 1 : 0), {tag, " request pulses"}, n_go - g0, expect_kind == 1 ? 1 : 0);
        chk((n_bad - b0) == (expect_kind == 2 ? 1 : 0), {tag, " reject pulses"}, n_bad - b0, expect_kind == 2 ? 1 : 0);
        if (expect_kind == 1) begin
            chk(req_addr == fb[2][7:1], {tag, " R6 address"}, req_addr, fb[2][7:1]);
            chk(req_count == fb[1], {tag, " R5 count"}, req_count, fb[1]);
        end else begin
            chk(req_addr == a0 && req_count == c0, {tag, " R12 outputs held"}, {req_addr, req_count}, {a0, c0});
        end
    endtask

    task automatic buf_check(input int n, input string tag);
        int lim = (n < 96) ? n : 96;
        int bad_k = -1;
        logic [7:0] got_v = '0;
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            rd_idx = 7'(k);
            #1;
            if (rd_data !== fb[3 + k] && bad_k < 0) begin
                bad_k = k;
                got_v = rd_data;
            end
        end
        chk(bad_k < 0, {tag, " R7 payload order"}, got_v, bad_k < 0 ? 0 : fb[3 + bad_k]);
    endtask

    task automatic build(input logic [7:0] cmd, input int cnt, input logic [7:0] addr, input int ndata);
        fb[0] = cmd;
        fb[1] = 8'(cnt);
        fb[2] = addr;
        for (int k = 0; k < ndata && k < 101; k++) fb[3 + k] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_valid == 0 && req_bad == 0, "R1 pulses low", {req_valid, req_bad}, 0);
        chk(req_addr == 0 && req_count == 0, "R1 request fields", {req_addr, req_count}, 0);
        chk(spi_miso == 1'b0, "R1 miso idle", spi_miso, 0);

        // R3 activity with select high
        begin
            int g0 = n_go;
            int b0 = n_bad;
            noise_cs_high(40);
            chk(n_go == g0 && n_bad == b0, "R3 no pulses while deselected", n_go - g0 + n_bad - b0, 0);
        end

        // R2/R6/R9 directed frame, address LSB set
        build(8'h00, 3, 8'hA5, 3);
        fb[3] = 8'hDE; fb[4] = 8'hAD; fb[5] = 8'h81;
        frame_check(6, 1'b0, 1, "R9 directed");
        buf_check(3, "R2 directed");

        // R4 wrong command
        build(8'h01, 2, 8'h30, 2);
        fb[3] = 8'h11; fb[4] = 8'h22;
        frame_check(5, 1'b0, 0, "R4 bad command");
        rd_idx = 7'd0; #1;
        chk(rd_data == 8'hDE, "R4 buffer untouched", rd_data, 8'hDE);

        // R10 short payload, long payload, missing address
        build(8'h00, 5, 8'h44, 3);
        frame_check(6, 1'b0, 2, "R10 short");
        build(8'h00, 2, 8'h44, 3);
        frame_check(6, 1'b0, 2, "R10 long");
        build(8'h00, 1, 8'h00, 0);
        frame_check(2, 1'b0, 2, "R10 header cut");

        // empty select window: nothing
        frame_check(0, 1'b0, 0, "R4 empty frame");

        // zero-length write
        build(8'h00, 0, 8'h7E, 0);
        frame_check(3, 1'b0, 1, "R9 zero count");

        // R11 last edge together with select release
        build(8'h00, 2, 8'h5B, 2);
        frame_check(5, 1'b1, 1, "R11 coincident release");
        buf_check(2, "R11 coincident release");

        // R8 over-limit count passed unchanged, storage capped
        build(8'h00, 100, 8'hC2, 100);
        frame_check(103, 1'b0, 1, "R8 over limit");
        rd_idx = 7'd95; #1;
        chk(rd_data == fb[3 + 95], "R8 last stored byte", rd_data, fb[3 + 95]);
        rd_idx = 7'd100; #1;
        chk(rd_data == 8'h00, "R7 out of range read", rd_data, 0);

        // R3 realignment: noise then random frames
        for (int f = 0; f < 6; f++) begin
            int cnt = (f == 0) ? 96 : int'($urandom % 97);
            noise_cs_high(int'($urandom % 9) + 1);
            build(8'h00, cnt, 8'($urandom), cnt);
            frame_check(3 + cnt, 1'($urandom), 1, "R3 random");
            buf_check(cnt, "R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule